// File: doc/BRIEF.md
# Dispatch Router into Issue Queue

This block takes one group of up to `W` renamed instruction slots per cycle and decides, slot by slot, what happens to each one. An ordinary instruction is written into the issue queue. An instruction that is a memory reference, nonspeculative or a no-op never enters the queue. It is routed straight toward commit already marked as issued, executed and ready to commit, and the queue tail is advanced for it. The queue storage and the scheduler sit outside this block. The caller supplies only the number of free queue entries.

The scan runs in ascending slot order. It ends at the first empty slot. It also ends at the first ordinary instruction that finds no free entry; in that case the block raises a block request and a stall toward rename. The per-slot accepted mask tells the stage controller which slots were consumed, so that the remaining valid slots can be placed in a skid buffer. While the stage is squashing, nothing is dispatched. All results are registered and appear one clock after the group is presented.

Top module: `dispatch_router`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is zero in the following cycle.
- R2: Slots are examined from index 0 upward. Slot i of every vector sits at bit i. The results for a group presented in cycle n appear on the outputs in cycle n+1.
- R3: The scan ends at the first slot whose valid bit is clear. That slot and every higher slot produce no insert strobe, no bypass strobe and no accepted bit.
- R4: A valid slot with the memory, nonspeculative or no-op flag set raises its bypass strobe and not its insert strobe. Its mark field `cmpl_mark[3*i+2:3*i]` equals {can-commit, executed, issued} = 3'b111. The mark field is 3'b000 for any slot that is not bypassed.
- R5: `tail_adv` is high exactly when at least one slot is bypassed. `tail_adv_n` gives the number of bypassed slots.
- R6: The bypass classification is decided before queue fullness is considered. A bypass instruction is routed even when no free entry remains, and it consumes no entry.
- R7: When an ordinary instruction is reached with no free entry left, `blk_req` and `stall_req` are both high, and that slot and every higher slot are left unprocessed.
- R8: Every insertion consumes one entry of `free_cnt`, and the remaining count is rechecked before each later slot. At most `free_cnt` inserts occur per group.
- R9: While `squashing` is high, no slot is inserted or bypassed, no slot is accepted, and neither block nor stall is raised.
- R10: `acc_mask` marks exactly the slots that were inserted or bypassed. It is always a contiguous run starting at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| squashing | input | 1 | Stage is squashing; suppresses dispatch |
| slot_vld | input | W | Slot holds an instruction |
| slot_mem | input | W | Slot is a memory reference |
| slot_nspec | input | W | Slot is nonspeculative |
| slot_nop | input | W | Slot is a no-op |
| free_cnt | input | FW | Free issue-queue entries this cycle |
| ins_stb | output | W | Slot written into the issue queue |
| byp_stb | output | W | Slot routed to commit, bypassing the queue |
| cmpl_mark | output | 3*W | Per slot {can-commit, executed, issued} |
| tail_adv | output | 1 | Queue tail advance for bypassed entries |
| tail_adv_n | output | CW | Number of bypassed slots |
| acc_mask | output | W | Slots consumed this group |
| blk_req | output | 1 | Block request, queue full |
| stall_req | output | 1 | Stall toward rename |

## Verification
The assertions assume that `free_cnt` and `squashing` are held steady for the whole cycle in which a group is presented. They also assume that the inputs hold known values once reset is released. The bound on the insert count compares the registered outputs against the previous cycle's `free_cnt`, so it relies on that value describing the same group. The stimulus changes every input only on the falling edge, and it presents one complete group together with its free count and squash flag in each call. No input is left unknown after reset.

// File: rtl/dr_pkg.sv
// Package: shared types for the dispatch router.
// Assumes: a bypassed slot carries all three completion marks together.
package dr_pkg;
    typedef struct packed {
        logic can_cmt;
        logic executed;
        logic issued;
    } cmpl_mark_t;

    localparam cmpl_mark_t MARK_DONE = '{can_cmt: 1'b1, executed: 1'b1, issued: 1'b1};
    localparam cmpl_mark_t MARK_NONE = '{can_cmt: 1'b0, executed: 1'b0, issued: 1'b0};
endpackage

// File: rtl/dr_slot_classify.sv
// Module: dr_slot_classify
// Tags each valid slot as a bypass candidate (memory, nonspeculative or
// no-op). Purely combinational. Assumes the class flags are meaningful only
// when the slot is valid.
module dr_slot_classify #(
    parameter int W = 4
) (
    input  logic [W-1:0] slot_vld,
    input  logic [W-1:0] slot_mem,
    input  logic [W-1:0] slot_nspec,
    input  logic [W-1:0] slot_nop,
    output logic [W-1:0] is_byp,
    output logic [W-1:0] is_norm
);
    for (genvar g = 0; g < W; g++) begin : g_cls
        // Bypass class wins over any notion of queue space.
        assign is_byp[g]  = slot_vld[g] & (slot_mem[g] | slot_nspec[g] | slot_nop[g]);
        assign is_norm[g] = slot_vld[g] & ~(slot_mem[g] | slot_nspec[g] | slot_nop[g]);
    end
endmodule

// File: rtl/dr_scan_chain.sv
// Module: dr_scan_chain
// Ordered scan across the slots. A live token and a remaining-room count
// ripple from slot 0 upward. Assumes free_cnt is the room at the start of
// the group. Combinational; the depth grows linearly with W.
module dr_scan_chain #(
    parameter int W  = 4,
    parameter int FW = 5,
    parameter int CW = 3
) (
    input  logic          squashing,
    input  logic [W-1:0]  is_byp,
    input  logic [W-1:0]  is_norm,
    input  logic [FW-1:0] free_cnt,
    output logic [W-1:0]  take_ins,
    output logic [W-1:0]  take_byp,
    output logic          full_hit,
    output logic [CW-1:0] byp_cnt
);
    logic [W:0]    live;
    logic [FW-1:0] room [0:W];
    logic [W-1:0]  hit;

    assign live[0] = ~squashing;
    assign room[0] = free_cnt;

    for (genvar g = 0; g < W; g++) begin : g_step
        // One slot's decision, then pass the token and the room onward.
        assign take_byp[g] = live[g] & is_byp[g];
        assign take_ins[g] = live[g] & is_norm[g] & (room[g] != '0);
        assign hit[g]      = live[g] & is_norm[g] & (room[g] == '0);
        assign live[g+1]   = take_byp[g] | take_ins[g];
        assign room[g+1]   = take_ins[g] ? room[g] - FW'(1) : room[g];
    end

    assign full_hit = |hit;

    // Count the bypassed slots for the tail advance.
    always_comb begin
        byp_cnt = '0;
        for (int i = 0; i < W; i++) byp_cnt = byp_cnt + CW'(take_byp[i]);
    end
endmodule

// File: rtl/dr_out_reg.sv
// Module: dr_out_reg
// Registers the routing results and expands the per-slot completion marks.
// Synchronous active-low reset clears everything.
module dr_out_reg
    import dr_pkg::*;
#(
    parameter int W  = 4,
    parameter int CW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   take_ins,
    input  logic [W-1:0]   take_byp,
    input  logic           full_hit,
    input  logic [CW-1:0]  byp_cnt,
    output logic [W-1:0]   ins_stb,
    output logic [W-1:0]   byp_stb,
    output logic [3*W-1:0] cmpl_mark,
    output logic           tail_adv,
    output logic [CW-1:0]  tail_adv_n,
    output logic [W-1:0]   acc_mask,
    output logic           blk_req,
    output logic           stall_req
);
    // Capture one group's decisions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins_stb    <= '0;
            byp_stb    <= '0;
            tail_adv   <= 1'b0;
            tail_adv_n <= '0;
            acc_mask   <= '0;
            blk_req    <= 1'b0;
            stall_req  <= 1'b0;
        end else begin
            ins_stb    <= take_ins;
            byp_stb    <= take_byp;
            tail_adv   <= |take_byp;
            tail_adv_n <= byp_cnt;
            acc_mask   <= take_ins | take_byp;
            blk_req    <= full_hit;
            stall_req  <= full_hit;
        end
    end

    for (genvar g = 0; g < W; g++) begin : g_mark
        // Expand the bypass bit into the three completion marks.
        assign cmpl_mark[3*g +: 3] = byp_stb[g] ? MARK_DONE : MARK_NONE;
    end
endmodule

// File: rtl/dispatch_router.sv
// Module: dispatch_router (top)
// Routes one rename group into the issue queue or straight to commit.
// Assumes free_cnt and squashing describe the cycle in which the group is
// presented. Results are registered and appear one cycle later.
module dispatch_router #(
    parameter int W     = 4,
    parameter int DEPTH = 16,
    parameter int FW    = $clog2(DEPTH + 1),
    parameter int CW    = $clog2(W + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           squashing,
    input  logic [W-1:0]   slot_vld,
    input  logic [W-1:0]   slot_mem,
    input  logic [W-1:0]   slot_nspec,
    input  logic [W-1:0]   slot_nop,
    input  logic [FW-1:0]  free_cnt,
    output logic [W-1:0]   ins_stb,
    output logic [W-1:0]   byp_stb,
    output logic [3*W-1:0] cmpl_mark,
    output logic           tail_adv,
    output logic [CW-1:0]  tail_adv_n,
    output logic [W-1:0]   acc_mask,
    output logic           blk_req,
    output logic           stall_req
);
    logic [W-1:0]  is_byp, is_norm, take_ins, take_byp;
    logic          full_hit;
    logic [CW-1:0] byp_cnt;

    dr_slot_classify #(.W(W)) u_cls (
        .slot_vld(slot_vld), .slot_mem(slot_mem), .slot_nspec(slot_nspec),
        .slot_nop(slot_nop), .is_byp(is_byp), .is_norm(is_norm)
    );

    dr_scan_chain #(.W(W), .FW(FW), .CW(CW)) u_scan (
        .squashing(squashing), .is_byp(is_byp), .is_norm(is_norm),
        .free_cnt(free_cnt), .take_ins(take_ins), .take_byp(take_byp),
        .full_hit(full_hit), .byp_cnt(byp_cnt)
    );

    dr_out_reg #(.W(W), .CW(CW)) u_out (
        .clk(clk), .rst_n(rst_n), .take_ins(take_ins), .take_byp(take_byp),
        .full_hit(full_hit), .byp_cnt(byp_cnt), .ins_stb(ins_stb),
        .byp_stb(byp_stb), .cmpl_mark(cmpl_mark), .tail_adv(tail_adv),
        .tail_adv_n(tail_adv_n), .acc_mask(acc_mask), .blk_req(blk_req),
        .stall_req(stall_req)
    );
endmodule

// File: rtl/dr_checker.sv
// Module: dr_checker
// Property checks on the router's ports, attached by bind.
module dr_checker #(
    parameter int W  = 4,
    parameter int FW = 5,
    parameter int CW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           squashing,
    input logic [W-1:0]   slot_vld,
    input logic [FW-1:0]  free_cnt,
    input logic [W-1:0]   ins_stb,
    input logic [W-1:0]   byp_stb,
    input logic           tail_adv,
    input logic [CW-1:0]  tail_adv_n,
    input logic [W-1:0]   acc_mask,
    input logic           blk_req,
    input logic           stall_req
);
    // R4
    no_dual_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_stb & byp_stb) == '0);

    // R3
    only_valid_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ins_stb | byp_stb) & ~$past(slot_vld)) == '0);

    // R5
    tail_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tail_adv |-> (byp_stb != '0) && (int'(tail_adv_n) == $countones(byp_stb)));

    // R7
    block_with_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_req |-> stall_req);

    // R8
    insert_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ins_stb) <= int'($past(free_cnt)));

    // R7
    full_means_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_req |-> $countones(ins_stb) == int'($past(free_cnt)));

    // R9
    squash_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(squashing) |-> (acc_mask == '0) && !blk_req && !stall_req);

    // R10
    contiguous_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_mask + W'(1)) & acc_mask) == '0);
endmodule

bind dispatch_router dr_checker #(.W(W), .FW(FW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .squashing(squashing), .slot_vld(slot_vld),
    .free_cnt(free_cnt), .ins_stb(ins_stb), .byp_stb(byp_stb),
    .tail_adv(tail_adv), .tail_adv_n(tail_adv_n), .acc_mask(acc_mask),
    .blk_req(blk_req), .stall_req(stall_req)
);

// File: tb/tb_dispatch_router.sv
// Directed bench for dispatch_router with W=4 and DEPTH=16.
module tb_dispatch_router;
    localparam int W = 4, FW = 5, CW = 3;

    logic clk = 1'b0, rst_n = 1'b0, squashing = 1'b0;
    logic [W-1:0] slot_vld = '0, slot_mem = '0, slot_nspec = '0, slot_nop = '0;
    logic [FW-1:0] free_cnt = '0;
    logic [W-1:0] ins_stb, byp_stb, acc_mask;
    logic [3*W-1:0] cmpl_mark;
    logic tail_adv, blk_req, stall_req;
    logic [CW-1:0] tail_adv_n;

    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    dispatch_router #(.W(W), .DEPTH(16)) dut (
        .clk(clk), .rst_n(rst_n), .squashing(squashing), .slot_vld(slot_vld),
        .slot_mem(slot_mem), .slot_nspec(slot_nspec), .slot_nop(slot_nop),
        .free_cnt(free_cnt), .ins_stb(ins_stb), .byp_stb(byp_stb),
        .cmpl_mark(cmpl_mark), .tail_adv(tail_adv), .tail_adv_n(tail_adv_n),
        .acc_mask(acc_mask), .blk_req(blk_req), .stall_req(stall_req)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one group on a falling edge; results are sampled at the next falling edge.
    task automatic present(input logic [3:0] v, input logic [3:0] m, input logic [3:0] ns,
                           input logic [3:0] np, input int fc, input logic sq);
        slot_vld = v; slot_mem = m; slot_nspec = ns; slot_nop = np;
        free_cnt = FW'(fc); squashing = sq;
        @(negedge clk);
    endtask

    task automatic expect_all(input string req, input logic [3:0] ins, input logic [3:0] byp,
                              input logic [3:0] acc, input logic blk, input int nb);
        logic [11:0] mk;
        mk = '0;
        for (int i = 0; i < W; i++) if (byp[i]) mk[3*i +: 3] = 3'b111;
        chk(req, "ins_stb", 32'(ins_stb), 32'(ins));
        chk(req, "byp_stb", 32'(byp_stb), 32'(byp));
        chk(req, "acc_mask", 32'(acc_mask), 32'(acc));
        chk(req, "blk_req", 32'(blk_req), 32'(blk));
        chk(req, "stall_req", 32'(stall_req), 32'(blk));
        chk(req, "cmpl_mark", 32'(cmpl_mark), 32'(mk));
        chk(req, "tail_adv", 32'(tail_adv), 32'(nb != 0));
        chk(req, "tail_adv_n", 32'(tail_adv_n), 32'(nb));
    endtask

    task automatic t_reset;   // R1
        present(4'b1111, 4'b0101, 4'b0, 4'b0, 8, 1'b0);
        expect_all("R1", 4'b0, 4'b0, 4'b0, 1'b0, 0);
    endtask

    task automatic t_plain;   // R2: all ordinary, plenty of room
        present(4'b1111, 4'b0, 4'b0, 4'b0, 8, 1'b0);
        expect_all("R2", 4'b1111, 4'b0, 4'b1111, 1'b0, 0);
    endtask

    task automatic t_hole;    // R3: slot 2 empty stops the scan
        present(4'b1011, 4'b0, 4'b0, 4'b0, 8, 1'b0);
        expect_all("R3", 4'b0011, 4'b0, 4'b0011, 1'b0, 0);
        present(4'b1110, 4'b0010, 4'b0, 4'b0, 8, 1'b0);
        expect_all("R3", 4'b0000, 4'b0, 4'b0000, 1'b0, 0);
    endtask

    task automatic t_classes; // R4 R5: mem, nonspec, nop each bypass
        present(4'b1111, 4'b0010, 4'b0100, 4'b1000, 8, 1'b0);
        expect_all("R4", 4'b0001, 4'b1110, 4'b1111, 1'b0, 3);
        present(4'b0011, 4'b0, 4'b0, 4'b0001, 8, 1'b0);
        expect_all("R5", 4'b0010, 4'b0001, 4'b0011, 1'b0, 1);
    endtask

    task automatic t_byp_prio; // R6: bypass passes an empty queue
        present(4'b1111, 4'b1001, 4'b0110, 4'b0, 0, 1'b0);
        expect_all("R6", 4'b0, 4'b1111, 4'b1111, 1'b0, 4);
    endtask

    task automatic t_full;    // R7: room for two of four
        present(4'b1111, 4'b0, 4'b0, 4'b0, 2, 1'b0);
        expect_all("R7", 4'b0011, 4'b0, 4'b0011, 1'b1, 0);
        present(4'b1111, 4'b0, 4'b0, 4'b1000, 0, 1'b0);
        expect_all("R7", 4'b0000, 4'b0, 4'b0000, 1'b1, 0);
    endtask

    task automatic t_recount; // R8: a bypass consumes no room
        present(4'b1111, 4'b0, 4'b0, 4'b0010, 1, 1'b0);
        expect_all("R8", 4'b0001, 4'b0010, 4'b0011, 1'b1, 1);
        present(4'b1111, 4'b0, 4'b0100, 4'b0, 3, 1'b0);
        expect_all("R8", 4'b1011, 4'b0100, 4'b1111, 1'b0, 1);
    endtask

    task automatic t_squash;  // R9 then recovery (R10)
        present(4'b1111, 4'b0001, 4'b0, 4'b0, 0, 1'b1);
        expect_all("R9", 4'b0, 4'b0, 4'b0, 1'b0, 0);
        present(4'b0111, 4'b0, 4'b0, 4'b0, 16, 1'b0);
        expect_all("R10", 4'b0111, 4'b0, 4'b0111, 1'b0, 0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_plain();
        t_hole();
        t_classes();
        t_byp_prio();
        t_full();
        t_recount();
        t_squash();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule